// File: doc/BRIEF.md
# Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a 16-bit down-counter that moves only on a one-cycle count-enable tick. The counter follows one of six counting behaviours, chosen by a 3-bit mode value that is captured when a count is written. The behaviours are:

- a terminal-count interrupt;
- a gate-retriggered one-shot;
- a rate generator;
- a square wave;
- a software strobe;
- a gate-retriggered strobe.

The host side decodes the bus and assembles the 16-bit value elsewhere. It then presents the value with a single load strobe.

The channel drives the live count and an OUT level. It also raises a flag that marks a freshly written count the counter has not yet used. A gate input suspends counting in some modes and retriggers it in others. A separate snapshot register captures the count on request, so that a read path can latch a stable value. Counting is always binary. A written zero stands for a terminal count of 65536.

Top module: `ivt_channel`

## Requirements
- R1: One cycle after a load strobe, count equals the written value. In modes 3 and 7 the written value's bit 0 is cleared first. The mode value is captured at the same time.
- R2: A written value of 0 acts as 65536. In mode 0, OUT rises on exactly the 65536th tick after the load.
- R3: In modes 0, 1, 4 and 5 each accepted tick lowers the count by one. The count wraps from 0 to 0xFFFF and never reloads.
- R4: Mode 0: OUT goes low on load. OUT goes high on the tick that takes the count from 1 to 0, and then stays high. Mode 1 behaves the same way after a load or a retrigger.
- R5: Mode 2 is periodic. On the tick at count 1 the counter reloads the written value. OUT is low exactly while the count is 1 and is high otherwise, so the period is N ticks for N of at least 2.
- R6: Mode 3 steps the count down by 2 per tick. On the tick at count 2 it reloads the even value and toggles OUT. OUT is high after load, and each half period lasts N/2 ticks.
- R7: Modes 4 and 5: OUT is high after load. OUT drops for exactly one tick when the count reaches 0, and only the first time.
- R8: In modes 0 and 4, ticks while gate is low leave the count unchanged. A rising gate edge never restarts these modes.
- R9: In modes 1, 2, 3 and 5, a rising gate edge reloads the written value (even value in mode 3). In mode 1 it also drives OUT low.
- R10: In modes 2 and 3, gate low holds the count and forces OUT high.
- R11: Modes 6 and 7 behave exactly as modes 2 and 3.
- R12: null_cnt is set by a load and cleared by the first tick after it.
- R13: A snap_req pulse copies the count into snap one cycle later. snap then holds until the next request.
- R14: After reset, count is 0, out is 0 and null_cnt is 0. Ticks before the first load change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable |
| gate | input | 1 | Gate level; rising edges are detected internally |
| load | input | 1 | Count write strobe |
| load_val | input | 16 | Value written with load |
| mode | input | 3 | Counting mode, captured with load |
| snap_req | input | 1 | Capture request for the snapshot register |
| count | output | 16 | Live counter value |
| out | output | 1 | Channel output level |
| null_cnt | output | 1 | Written count not yet counted from |
| snap | output | 16 | Snapshot of count |

## Verification
The following results appear on the outputs one clock edge after the cycle that caused them:

- a load;
- a tick;
- a snapshot request;
- a gate level first seen high.

All state is held in a single register stage, so no result takes longer than that. The bench changes inputs on the falling edge and samples on the next falling edge. Each check therefore lands exactly one rising edge after its stimulus. For multi-tick runs, the expected count and OUT are computed from the number of ticks applied. Long windows such as the 65536-tick terminal count are bounded by the tick count, not by delays.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [2:0] {
        MD_TC_INT    = 3'd0,
        MD_ONE_SHOT  = 3'd1,
        MD_RATE      = 3'd2,
        MD_SQUARE    = 3'd3,
        MD_SW_STROBE = 3'd4,
        MD_HW_STROBE = 3'd5
    } ivt_mode_e;

    // codes 6 and 7 fold onto the periodic modes
    function automatic ivt_mode_e ivt_norm_mode(input logic [2:0] raw);
        if (raw[2:1] == 2'b11) return ivt_mode_e'({1'b0, raw[1:0]});
        return ivt_mode_e'(raw);
    endfunction

endpackage

// File: rtl/ivt_gate_sense.sv
module ivt_gate_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic gate_rise
);
    logic gate_d, gate_q;

    always_comb gate_d = gate;

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

    assign gate_rise = gate & ~gate_q;

endmodule

// File: rtl/ivt_mode_decode.sv
module ivt_mode_decode
    import ivt_pkg::*;
(
    input  logic [2:0] mode_raw,
    output ivt_mode_e  mode_eff,
    output logic       gate_pauses,
    output logic       gate_retrig,
    output logic       periodic
);
    always_comb begin
        mode_eff    = ivt_norm_mode(mode_raw);
        gate_pauses = 1'b0;
        gate_retrig = 1'b0;
        periodic    = 1'b0;
        case (mode_eff)
            MD_TC_INT, MD_SW_STROBE: gate_pauses = 1'b1;
            MD_ONE_SHOT, MD_HW_STROBE: gate_retrig = 1'b1;
            MD_RATE, MD_SQUARE: begin
                gate_pauses = 1'b1;
                gate_retrig = 1'b1;
                periodic    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [2:0]       mode,
    input  logic             snap_req,
    output logic [CNT_W-1:0] count,
    output logic             out,
    output logic             null_cnt,
    output logic [CNT_W-1:0] snap
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);
    localparam logic [CNT_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] snap;
        logic [2:0]       mode;
        logic             out;
        logic             nul;
        logic             done;
        logic             armed;
    } ivt_state_t;

    ivt_state_t st_d, st_q;

    logic      gate_rise;
    ivt_mode_e cur_mode;
    logic      cur_pauses, cur_retrig, cur_periodic;
    ivt_mode_e ld_mode;
    logic [CNT_W-1:0] start_val;

    ivt_gate_sense u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (gate),
        .gate_rise (gate_rise)
    );

    ivt_mode_decode u_dec (
        .mode_raw    (st_q.mode),
        .mode_eff    (cur_mode),
        .gate_pauses (cur_pauses),
        .gate_retrig (cur_retrig),
        .periodic    (cur_periodic)
    );

    always_comb begin
        ld_mode   = ivt_norm_mode(mode);
        start_val = (cur_mode == MD_SQUARE) ? {st_q.reload[CNT_W-1:1], 1'b0}
                                            : st_q.reload;
    end

    always_comb begin
        st_d = st_q;
        if (snap_req) st_d.snap = st_q.cnt;
        if (load) begin
            st_d.mode   = mode;
            st_d.reload = load_val;
            st_d.cnt    = (ld_mode == MD_SQUARE) ? {load_val[CNT_W-1:1], 1'b0}
                                                 : load_val;
            st_d.armed  = 1'b1;
            st_d.nul    = 1'b1;
            st_d.done   = 1'b0;
            st_d.out    = !(ld_mode == MD_TC_INT || ld_mode == MD_ONE_SHOT);
        end else if (st_q.armed) begin
            if (tick) st_d.nul = 1'b0;
            if (gate_rise && cur_retrig) begin
                st_d.cnt  = start_val;
                st_d.done = 1'b0;
                st_d.out  = (cur_mode != MD_ONE_SHOT);
            end else if (cur_periodic && !gate) begin
                st_d.out = 1'b1;
            end else if (tick && !(cur_pauses && !gate)) begin
                case (cur_mode)
                    MD_TC_INT, MD_ONE_SHOT: begin
                        st_d.cnt = st_q.cnt - ONE;
                        if (st_q.cnt == ONE && !st_q.done) begin
                            st_d.out  = 1'b1;
                            st_d.done = 1'b1;
                        end
                    end
                    MD_SW_STROBE, MD_HW_STROBE: begin
                        st_d.cnt = st_q.cnt - ONE;
                        st_d.out = 1'b1;
                        if (st_q.cnt == ONE && !st_q.done) begin
                            st_d.out  = 1'b0;
                            st_d.done = 1'b1;
                        end
                    end
                    MD_RATE: begin
                        if (st_q.cnt == ONE) begin
                            st_d.cnt = st_q.reload;
                            st_d.out = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt - ONE;
                            st_d.out = (st_q.cnt != TWO);
                        end
                    end
                    MD_SQUARE: begin
                        if (st_q.cnt == TWO) begin
                            st_d.cnt = start_val;
                            st_d.out = ~st_q.out;
                        end else begin
                            st_d.cnt = st_q.cnt - TWO;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt    <= ZERO;
            st_q.reload <= ZERO;
            st_q.snap   <= ZERO;
            st_q.mode   <= 3'd0;
            st_q.out    <= 1'b0;
            st_q.nul    <= 1'b0;
            st_q.done   <= 1'b0;
            st_q.armed  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.cnt;
    assign out      = st_q.out;
    assign null_cnt = st_q.nul;
    assign snap     = st_q.snap;

    // R1: written value reaches the counter (non-square modes)
    p_load_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode[1:0] != 2'b11) |=> (count == $past(load_val)));

    // R3: binary wrap with no reload in mode 0
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && cur_mode == MD_TC_INT && tick && gate && !load && count == ZERO)
        |=> (count == {CNT_W{1'b1}}));

    // R8: gate low freezes the count in modes 0 and 4
    p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && (cur_mode == MD_TC_INT || cur_mode == MD_SW_STROBE)
         && !gate && !load) |=> $stable(count));

    // R10: periodic modes with gate low drive OUT high
    p_gate_out_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && cur_periodic && !gate && !load) |=> out);

    // R12: load sets the flag, a tick clears it
    p_null_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> null_cnt);
    p_null_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (null_cnt && tick && !load) |=> !null_cnt);

endmodule

// File: tb/ivt_channel_test.sv
module ivt_channel_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        gate = 1'b1;
    logic        load = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  mode = '0;
    logic        snap_req = 1'b0;
    logic [15:0] count;
    logic        out;
    logic        null_cnt;
    logic [15:0] snap;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivt_channel uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
        .load_val(load_val), .mode(mode), .snap_req(snap_req),
        .count(count), .out(out), .null_cnt(null_cnt), .snap(snap)
    );

    typedef struct packed {
        logic [2:0]  m;
        logic [15:0] v;
        logic [15:0] n;
        logic [15:0] c;
        logic        o;
    } vec_t;

    // mode, written value, ticks, expected count, expected out
    localparam vec_t VECS [20] = '{
        '{3'd0, 16'd10, 16'd3,  16'd7,      1'b0},  // R3 R4
        '{3'd0, 16'd10, 16'd10, 16'd0,      1'b1},  // R4
        '{3'd0, 16'd5,  16'd7,  16'hFFFE,   1'b1},  // R3 wrap
        '{3'd2, 16'd5,  16'd3,  16'd2,      1'b1},  // R5
        '{3'd2, 16'd5,  16'd4,  16'd1,      1'b0},  // R5
        '{3'd2, 16'd5,  16'd5,  16'd5,      1'b1},  // R5 reload
        '{3'd2, 16'd5,  16'd7,  16'd3,      1'b1},  // R5
        '{3'd3, 16'd8,  16'd3,  16'd2,      1'b1},  // R6
        '{3'd3, 16'd8,  16'd4,  16'd8,      1'b0},  // R6 toggle
        '{3'd3, 16'd9,  16'd4,  16'd8,      1'b0},  // R6 odd value
        '{3'd3, 16'd8,  16'd8,  16'd8,      1'b1},  // R6 second toggle
        '{3'd4, 16'd3,  16'd2,  16'd1,      1'b1},  // R7
        '{3'd4, 16'd3,  16'd3,  16'd0,      1'b0},  // R7 pulse
        '{3'd4, 16'd3,  16'd4,  16'hFFFF,   1'b1},  // R7 pulse ends
        '{3'd5, 16'd3,  16'd3,  16'd0,      1'b0},  // R7 mode 5
        '{3'd1, 16'd4,  16'd2,  16'd2,      1'b0},  // R4 mode 1
        '{3'd1, 16'd4,  16'd4,  16'd0,      1'b1},  // R4 mode 1
        '{3'd6, 16'd5,  16'd4,  16'd1,      1'b0},  // R11
        '{3'd7, 16'd8,  16'd4,  16'd8,      1'b0},  // R11
        '{3'd4, 16'd3,  16'd5,  16'hFFFE,   1'b1}   // R7 single pulse
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [2:0] m, input logic [15:0] v);
        @(negedge clk);
        load = 1'b1; mode = m; load_val = v;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            for (int i = 0; i < n; i++) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R14 reset state and no effect before a load
        check("R14 count", count, 16'd0);
        check("R14 out", {15'd0, out}, 16'd0);
        check("R14 null", {15'd0, null_cnt}, 16'd0);
        do_ticks(3);
        check("R14 ticks before load", count, 16'd0);

        // R1 and R12
        do_load(3'd0, 16'h1234);
        check("R1 load value", count, 16'h1234);
        check("R12 null set", {15'd0, null_cnt}, 16'd1);
        do_ticks(1);
        check("R12 null cleared", {15'd0, null_cnt}, 16'd0);
        check("R3 decrement", count, 16'h1233);
        do_load(3'd3, 16'd9);
        check("R1 mode 3 even", count, 16'd8);

        // table walk
        for (int k = 0; k < 20; k++) begin
            do_load(VECS[k].m, VECS[k].v);
            do_ticks(int'(VECS[k].n));
            check($sformatf("R3-R7/R11 vec%0d count", k), count, VECS[k].c);
            check($sformatf("R4-R7/R11 vec%0d out", k), {15'd0, out}, {15'd0, VECS[k].o});
        end

        // R2 zero means 65536
        do_load(3'd0, 16'd0);
        do_ticks(65535);
        check("R2 before terminal out", {15'd0, out}, 16'd0);
        check("R2 before terminal count", count, 16'd1);
        do_ticks(1);
        check("R2 terminal out", {15'd0, out}, 16'd1);

        // R8 gate pauses, no restart
        do_load(3'd0, 16'd10);
        gate = 1'b0;
        do_ticks(5);
        check("R8 gate low hold", count, 16'd10);
        gate = 1'b1;
        idle(2);
        check("R8 no restart", count, 16'd10);
        do_ticks(2);
        check("R8 resume", count, 16'd8);

        // R9 retrigger in mode 1
        do_load(3'd1, 16'd10);
        do_ticks(10);
        check("R9 mode1 done out", {15'd0, out}, 16'd1);
        gate = 1'b0;
        idle(1);
        gate = 1'b1;
        idle(1);
        check("R9 mode1 retrig count", count, 16'd10);
        check("R9 mode1 retrig out", {15'd0, out}, 16'd0);

        // R9 retrigger in mode 2
        do_load(3'd2, 16'd5);
        do_ticks(2);
        check("R9 mode2 pre", count, 16'd3);
        gate = 1'b0;
        idle(1);
        gate = 1'b1;
        idle(1);
        check("R9 mode2 retrig", count, 16'd5);

        // R10 gate low in mode 3
        do_load(3'd3, 16'd8);
        do_ticks(4);
        check("R10 pre out", {15'd0, out}, 16'd0);
        gate = 1'b0;
        idle(1);
        check("R10 out forced high", {15'd0, out}, 16'd1);
        do_ticks(3);
        check("R10 count held", count, 16'd8);
        gate = 1'b1;
        idle(1);

        // R13 snapshot
        do_load(3'd0, 16'd100);
        do_ticks(10);
        @(negedge clk);
        snap_req = 1'b1;
        @(negedge clk);
        snap_req = 1'b0;
        check("R13 snap", snap, 16'd90);
        do_ticks(5);
        check("R13 count moves", count, 16'd85);
        check("R13 snap held", snap, 16'd90);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule